// File: doc/BRIEF.md
# DMA Address Hold Loop Generator

This block produces the byte address for each beat on one side (read side or write side) of a DMA transfer. A start pulse loads a base address, a byte count and a configuration word; each advance strobe then consumes one byte and moves the address on. In linear mode the address climbs by one per byte across the whole transfer. In hold mode the address walks a small power-of-two window of 1, 2, 4 or 8 bytes anchored at the base and wraps back to the base, which suits a peripheral data port that exposes a short register window as a FIFO.

The same module serves either side. A parameter picks which hold-enable bit and which window-size field of the shared configuration word the instance decodes, so read-side and write-side instances fed with the same word hold independently. A base address that is not aligned to the chosen window is refused at start: an error flag rises and no address is offered. Data movement and descriptor handling live elsewhere.

Top module: `addr_hold_loop_gen`

## Requirements
- R1: After reset, addr_valid, done and align_err are all 0.
- R2: With the decoded hold-enable bit clear, the address of beat n (counting from 0) is base + n, for any base alignment.
- R3: With hold enabled, the window size is 2^k bytes where k is a 2-bit field of cfg_word (bits 15:14 for the read side, bits 17:16 for the write side), and the address of beat n is base + (n mod 2^k).
- R4: With hold enabled and k = 0, the address stays at the base for every beat.
- R5: The hold-enable bit is cfg_word bit 12 for the read side (IS_WRITE_SIDE = 0) and bit 13 for the write side (IS_WRITE_SIDE = 1); each instance ignores the other side's enable bit and size field.
- R6: The advance that consumes the last byte sets done and clears addr_valid from the next cycle; later advance strobes leave addr, done and addr_valid unchanged until the next start.
- R7: A start with hold enabled and a base not aligned to 2^k sets align_err, keeps addr_valid and done at 0, and later advances have no effect.
- R8: A start, even in the middle of a transfer and even with advance high in the same cycle, reloads base and length, returns the window offset to 0 and clears done and align_err; the address in the following cycle is the new base.
- R9: A start with a byte count of 0 (and no alignment error) sets done at once and never raises addr_valid.
- R10: While addr_valid is 0 and no start is given, advance strobes change none of addr, done and align_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load pulse for a new transfer |
| base_addr | input | ADDR_W | First byte address, sampled on start |
| byte_len | input | LEN_W | Number of bytes, sampled on start |
| cfg_word | input | CFG_W | Configuration word holding both sides' hold settings, sampled on start |
| advance | input | 1 | One byte consumed at the current address |
| addr | output | ADDR_W | Current byte address |
| addr_valid | output | 1 | addr holds a beat still to be transferred |
| done | output | 1 | All bytes of the transfer consumed |
| align_err | output | 1 | Last start was refused for a misaligned base |

## Verification
The hardest situation to reach is a wrap of the window coinciding with a restart or with the final byte, together with both sides decoding one configuration word differently. The bench drives a read-side and a write-side instance from the same stimulus, so random configuration words produce every mix of hold, linear and refused sides in one transfer, and random idle gaps between strobes let starts land mid-window. Directed cases add a start with advance held high, lengths that end exactly on a wrap, and strobes after completion.

// File: rtl/addr_hold_pkg.sv
package addr_hold_pkg;

  localparam int unsigned RD_HOLD_EN_BIT = 12;
  localparam int unsigned WR_HOLD_EN_BIT = 13;
  localparam int unsigned RD_WIN_LSB     = 14;
  localparam int unsigned WR_WIN_LSB     = 16;

  typedef struct packed {
    logic       hold;
    logic [1:0] win_log2;
  } hold_cfg_t;

  // Low-order mask covering the offsets inside a 2^k byte window.
  function automatic logic [7:0] win_low_mask(input logic [1:0] k);
    logic [7:0] m;
    case (k)
      2'd0:    m = 8'h00;
      2'd1:    m = 8'h01;
      2'd2:    m = 8'h03;
      default: m = 8'h07;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ahl_cfg_decode.sv
module ahl_cfg_decode
  import addr_hold_pkg::*;
#(
  parameter int unsigned CFG_W         = 32,
  parameter bit          IS_WRITE_SIDE = 1'b0
) (
  input  logic [CFG_W-1:0] cfg_word,
  output hold_cfg_t        cfg
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_word;

  generate
    if (IS_WRITE_SIDE) begin : g_write
      assign cfg.hold     = cfg_word[WR_HOLD_EN_BIT];
      assign cfg.win_log2 = cfg_word[WR_WIN_LSB +: 2];
    end else begin : g_read
      assign cfg.hold     = cfg_word[RD_HOLD_EN_BIT];
      assign cfg.win_log2 = cfg_word[RD_WIN_LSB +: 2];
    end
  endgenerate

endmodule

// File: rtl/ahl_offset_step.sv
module ahl_offset_step
  import addr_hold_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  hold_cfg_t         cfg,
  output logic [ADDR_W-1:0] offset
);

  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] offset_d;
  logic              offset_en;

  always_comb begin
    wrap_mask = cfg.hold ? ADDR_W'(win_low_mask(cfg.win_log2)) : '1;
    offset_en = clr | step;
    if (clr) offset_d = '0;
    else     offset_d = (offset + ADDR_W'(1)) & wrap_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         offset <= '0;
    else if (offset_en) offset <= offset_d;
  end

endmodule

// File: rtl/ahl_byte_count.sv
module ahl_byte_count #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] remaining,
  output logic             last
);

  logic [LEN_W-1:0] rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load | dec;
    if (load) rem_d = load_val;
    else      rem_d = remaining - LEN_W'(1);
    last = (remaining == LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remaining <= '0;
    else if (rem_en) remaining <= rem_d;
  end

endmodule

// File: rtl/addr_hold_loop_gen.sv
module addr_hold_loop_gen
  import addr_hold_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned LEN_W         = 12,
  parameter int unsigned CFG_W         = 32,
  parameter bit          IS_WRITE_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic              done,
  output logic              align_err
);

  hold_cfg_t         cfg_in;
  hold_cfg_t         cfg_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] offset;
  logic [LEN_W-1:0]  remaining;
  logic              last_byte;
  logic              active_q, done_q, err_q;
  logic              active_d, done_d, err_d;
  logic              misaligned, zero_len, beat, ctl_en;

  ahl_cfg_decode #(.CFG_W(CFG_W), .IS_WRITE_SIDE(IS_WRITE_SIDE)) u_dec (
    .cfg_word (cfg_word),
    .cfg      (cfg_in)
  );

  always_comb begin
    misaligned = cfg_in.hold &&
                 ((base_addr & ADDR_W'(win_low_mask(cfg_in.win_log2))) != '0);
    zero_len   = (byte_len == '0);
    beat       = advance && active_q && !start;
    ctl_en     = start | beat;
    if (start) begin
      active_d = !misaligned && !zero_len;
      done_d   = !misaligned && zero_len;
      err_d    = misaligned;
    end else begin
      active_d = !last_byte;
      done_d   = last_byte;
      err_d    = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (ctl_en) begin
      active_q <= active_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else if (start) begin
      base_q <= base_addr;
      cfg_q  <= cfg_in;
    end
  end

  ahl_offset_step #(.ADDR_W(ADDR_W)) u_off (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .step   (beat),
    .cfg    (cfg_q),
    .offset (offset)
  );

  ahl_byte_count #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_val  (byte_len),
    .dec       (beat),
    .remaining (remaining),
    .last      (last_byte)
  );

  assign addr       = base_q + offset;
  assign addr_valid = active_q;
  assign done       = done_q;
  assign align_err  = err_q;

endmodule

// File: rtl/addr_hold_loop_gen_chk.sv
module addr_hold_loop_gen_chk
  import addr_hold_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic              advance,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_valid,
  input logic              done,
  input logic              align_err,
  input logic [ADDR_W-1:0] base_q,
  input logic              hold_q,
  input logic [1:0]        win_log2_q,
  input logic [LEN_W-1:0]  remaining
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!addr_valid && !done && !align_err));

  p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !hold_q && advance && !start && remaining != LEN_W'(1))
      |=> (addr == $past(addr) + ADDR_W'(1)));

  p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && hold_q)
      |-> (((addr - base_q) & ~ADDR_W'(win_low_mask(win_log2_q))) == '0));

  p_fixed_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && hold_q && win_log2_q == 2'd0) |-> (addr == base_q));

  p_valid_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && done));

  p_err_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!addr_valid && !done));

  p_start_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr == $past(base_addr)));

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !start) |=> ($stable(addr) && $stable(done) && $stable(align_err)));

endmodule

bind addr_hold_loop_gen addr_hold_loop_gen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .base_addr  (base_addr),
  .advance    (advance),
  .addr       (addr),
  .addr_valid (addr_valid),
  .done       (done),
  .align_err  (align_err),
  .base_q     (base_q),
  .hold_q     (cfg_q.hold),
  .win_log2_q (cfg_q.win_log2),
  .remaining  (remaining)
);

// File: tb/addr_hold_loop_gen_test.sv
`timescale 1ns/1ps
module addr_hold_loop_gen_test;

  localparam int unsigned AW = 32;
  localparam int unsigned LW = 12;
  localparam int unsigned CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] byte_len = '0;
  logic [CW-1:0] cfg_word = '0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr_rd, addr_wr;
  logic          valid_rd, valid_wr, done_rd, done_wr, err_rd, err_wr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr_hold_loop_gen #(.ADDR_W(AW), .LEN_W(LW), .CFG_W(CW), .IS_WRITE_SIDE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .byte_len(byte_len), .cfg_word(cfg_word), .advance(advance),
    .addr(addr_rd), .addr_valid(valid_rd), .done(done_rd), .align_err(err_rd));

  addr_hold_loop_gen #(.ADDR_W(AW), .LEN_W(LW), .CFG_W(CW), .IS_WRITE_SIDE(1'b1)) uut_wr (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .byte_len(byte_len), .cfg_word(cfg_word), .advance(advance),
    .addr(addr_wr), .addr_valid(valid_wr), .done(done_wr), .align_err(err_wr));

  // Expected-value model, written from the requirements.
  function automatic bit m_hold(input logic [CW-1:0] w, input bit wr);
    return wr ? w[13] : w[12];
  endfunction
  function automatic int m_log2(input logic [CW-1:0] w, input bit wr);
    return wr ? int'(w[17:16]) : int'(w[15:14]);
  endfunction
  function automatic bit m_misal(input logic [CW-1:0] w, input bit wr, input logic [AW-1:0] b);
    int win;
    win = 1 << m_log2(w, wr);
    return m_hold(w, wr) && ((b % win) != 0);
  endfunction
  function automatic logic [AW-1:0] m_addr(input logic [CW-1:0] w, input bit wr,
                                           input logic [AW-1:0] b, input int n);
    int win;
    win = 1 << m_log2(w, wr);
    if (m_hold(w, wr)) return b + AW'(n % win);
    return b + AW'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [AW-1:0] cur_base;
  logic [LW-1:0] cur_len;
  logic [CW-1:0] cur_cfg;
  int            beats;

  // Compare one side with the model after `beats` accepted strobes.
  task automatic check_side(input bit wr, input string req);
    logic [AW-1:0] a; logic v, d, e;
    a = wr ? addr_wr : addr_rd;
    v = wr ? valid_wr : valid_rd;
    d = wr ? done_wr : done_rd;
    e = wr ? err_wr : err_rd;
    if (m_misal(cur_cfg, wr, cur_base)) begin
      chk(e && !v && !d, {req, " R7 refused"}, {29'd0, e, v, d}, 32'h4);
    end else if (beats >= int'(cur_len)) begin
      chk(d && !v && !e, {req, " R6/R9 done"}, {29'd0, e, v, d}, 32'h1);
    end else begin
      chk(v && !d && !e, {req, " valid"}, {29'd0, e, v, d}, 32'h2);
      chk(a == m_addr(cur_cfg, wr, cur_base, beats), {req, " addr"},
          a, m_addr(cur_cfg, wr, cur_base, beats));
    end
  endtask

  task automatic check_both(input string req);
    check_side(1'b0, req);
    check_side(1'b1, req);
  endtask

  task automatic do_start(input logic [AW-1:0] b, input logic [LW-1:0] l,
                          input logic [CW-1:0] c, input bit adv_too);
    @(negedge clk);
    start = 1'b1; base_addr = b; byte_len = l; cfg_word = c; advance = adv_too;
    @(posedge clk); #1;
    cur_base = b; cur_len = l; cur_cfg = c; beats = 0;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    base_addr = $urandom; byte_len = LW'($urandom); cfg_word = $urandom;
  endtask

  task automatic strobe(input string req);
    bit live;
    live = (!m_misal(cur_cfg, 1'b0, cur_base) || !m_misal(cur_cfg, 1'b1, cur_base));
    @(negedge clk);
    advance = 1'b1;
    @(posedge clk); #1;
    if (beats < int'(cur_len)) beats++;
    check_both(req);
    if (!live) beats = beats;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic run(input logic [AW-1:0] b, input logic [LW-1:0] l,
                     input logic [CW-1:0] c, input int extra, input int gap, input string req);
    do_start(b, l, c, 1'b0);
    check_both({req, " start R8"});
    for (int i = 0; i < int'(l) + extra; i++) begin
      int g;
      g = (gap > 0) ? $urandom_range(gap, 0) : 0;
      for (int j = 0; j < g; j++) begin
        @(negedge clk); @(posedge clk); #1;
        check_both({req, " idle gap"});
      end
      strobe(req);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h00c0ffee));
    cur_base = '0; cur_len = '0; cur_cfg = '0; beats = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!valid_rd && !done_rd && !err_rd && !valid_wr && !done_wr && !err_wr,
        "R1 reset idle", {26'd0, valid_rd, done_rd, err_rd, valid_wr, done_wr, err_wr}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!valid_rd && !done_rd && !err_rd, "R1 after release",
        {29'd0, valid_rd, done_rd, err_rd}, 32'h0);

    // R10: strobes before any start change nothing.
    @(negedge clk); advance = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(addr_rd == '0 && !done_rd && !err_rd, "R10 strobe while idle", addr_rd, 32'h0);
    @(negedge clk); advance = 1'b0;

    // R2: linear on both sides, odd base, extra strobes after the end (R6).
    run(32'h0000_1003, 12'd6, 32'h0000_0000, 3, 0, "R2 linear");

    // R3: read side window 4 (bit12, k=2 at 15:14), write side linear (R5).
    run(32'h0000_0100, 12'd11, 32'h0000_9000, 2, 1, "R3 rd win4 R5");

    // R3: write side window 8 (bit13, k=3 at 17:16), read field set but enable off (R5).
    run(32'h0000_2008, 12'd16, 32'h0003_e000 & ~32'h0000_1000, 1, 0, "R3 wr win8 R5");

    // R4: window 1 on both sides.
    run(32'h0000_0777, 12'd5, 32'h0000_3000, 1, 0, "R4 fixed");

    // R3: window 2 ending exactly on a wrap.
    run(32'h0000_0042, 12'd4, 32'h0000_5000, 1, 0, "R3 win2 wrap end");

    // R7: read side misaligned for window 8, write side linear continues.
    run(32'h0000_0104, 12'd5, 32'h0000_d000, 2, 0, "R7 misaligned rd");

    // R9: zero length.
    run(32'h0000_0010, 12'd0, 32'h0000_0000, 2, 0, "R9 zero length");

    // R8: restart mid-transfer with advance high in the start cycle.
    do_start(32'h0000_0200, 12'd9, 32'h0000_9000, 1'b0);
    strobe("R8 pre"); strobe("R8 pre"); strobe("R8 pre");
    do_start(32'h0000_0300, 12'd3, 32'h0000_9000, 1'b1);
    check_both("R8 restart with advance");
    chk(addr_rd == 32'h0000_0300, "R8 new base", addr_rd, 32'h0000_0300);
    strobe("R8 post"); strobe("R8 post"); strobe("R8 post"); strobe("R8 post");

    // R8: restart clears a refusal.
    do_start(32'h0000_0101, 12'd2, 32'h0000_5000, 1'b0);
    chk(err_rd == 1'b1, "R7 refused before restart", {31'd0, err_rd}, 32'h1);
    do_start(32'h0000_0102, 12'd2, 32'h0000_5000, 1'b0);
    chk(err_rd == 1'b0 && valid_rd, "R8 restart clears error", {31'd0, err_rd}, 32'h0);
    strobe("R8 after clear"); strobe("R8 after clear");

    // Random mix.
    for (int t = 0; t < 60; t++) begin
      logic [AW-1:0] b; logic [CW-1:0] c; logic [LW-1:0] l;
      b = $urandom;
      if ($urandom_range(3, 0) != 0) b = b & ~32'h7;
      c = $urandom;
      l = LW'($urandom_range(20, 0));
      run(b, l, c, $urandom_range(2, 0), 2, "R2/R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule